// File: doc/BRIEF.md
# Two-Port Atomic Word Memory with Reservations

This block is a small word-addressed memory shared by two requesters. Each requester can read, write, take a reservation on a word (load-linked), attempt a write that only lands if that reservation is still intact (store-conditional), and perform a compare-and-swap. The block holds one reservation per requester. That reservation is a valid flag and a word address. Every successful write to a word breaks the other requester's reservation on that word. Software builds lock-free updates and spin locks from these operations. It loops on a conditional store until the store reports success.

The memory has a single access port, so at most one load, store, load-linked, successful conditional store or compare-and-swap runs per cycle. When both requesters want the port in the same cycle, a round-robin arbiter chooses between them, so a retry loop on one side cannot starve the other side. A conditional store that is already doomed needs no port. This is the case when its requester has no reservation, or the reservation is on another address. Such a store is accepted at once, in parallel with whatever the other side is doing. Every successful write also raises a one-cycle invalidation pulse with the written address. This stands in for the bus traffic that other caches would observe.

Requests use valid/ready. A requester holds `req_valid` and its fields steady until it sees `req_ready` high at a clock edge. `req_ready` is a combinational function of the current requests, so it may depend on `req_valid` in the same cycle. Each accepted request produces exactly one response one cycle later. Responses cannot be back-pressured.

Top module: `atomic_mem_unit`

## Requirements
- R1: Operation codes are 0 load, 1 store, 2 load-linked, 3 store-conditional, 4 compare-and-swap; codes 5 to 7 act as load. A load returns the addressed word with ok=1. A store writes the word and returns ok=1 with read data 0.
- R2: A load-linked returns the current word with ok=1 and records a reservation on its address for its requester. A later store-conditional from that requester to that address, with no write in between, writes its data and returns ok=1 with read data 0.
- R3: A store-conditional whose reserved word was written by the other requester (plain store, conditional store or successful compare-and-swap) after the load-linked returns ok=0 and leaves the word unchanged.
- R4: Every successful write raises `inval_pulse` for one cycle, in the same cycle as its response, with `inval_addr` equal to the written address. A failed store-conditional or a failed compare-and-swap raises no pulse.
- R5: When both requesters issue store-conditional to the same word, each with a valid reservation on it, in the same cycle, the arbitration winner succeeds and the other returns ok=0.
- R6: A store-conditional without a matching reservation is accepted in the cycle it is presented, even while the other requester uses the port, and returns ok=0 with read data 0.
- R7: Compare-and-swap returns the old word. When the old word equals `req_cmp`, it writes `req_wdata`, returns ok=1 and breaks the other requester's matching reservation. Otherwise it returns ok=0 and changes neither memory nor any reservation.
- R8: A requester's own store-conditional clears its reservation, whether it succeeds or fails. A newer load-linked replaces the older reservation.
- R9: At most one port operation is granted per cycle. When both requesters want the port, the one not served most recently through the port wins. After reset, requester 0 is favoured. The loser's `req_ready` stays low.
- R10: Each accepted request gives exactly one response, with `rsp_valid` high in the cycle right after the acceptance edge. No response appears without an acceptance.
- R11: Reset clears every word to 0, removes both reservations and holds `rsp_valid` and `inval_pulse` low.
- R12: A write to a different address does not disturb a reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 2 | Request valid, one bit per requester |
| req_ready | output | 2 | Request accepted at this edge, one bit per requester |
| req_op | input | 2x3 | Operation code per requester |
| req_addr | input | 2xADDR_W | Word address per requester |
| req_wdata | input | 2xDATA_W | Store data, or new value for compare-and-swap |
| req_cmp | input | 2xDATA_W | Expected value for compare-and-swap |
| rsp_valid | output | 2 | Response valid, one bit per requester |
| rsp_rdata | output | 2xDATA_W | Response read data |
| rsp_ok | output | 2 | Success flag: 1 success, 0 failure |
| inval_pulse | output | 1 | One-cycle pulse on each successful write |
| inval_addr | output | ADDR_W | Address written, valid with the pulse |

## Verification
The hardest case is a true race: both requesters must hold reservations on the same word and both present conditional stores on the same edge. The bench has each side take a load-linked in turn, which leaves the arbiter's preference known. It then launches both conditional stores from parallel branches at the same falling edge. The winner's write must break the loser's reservation. The loser must then be turned away on the next cycle through the fast-fail path, with no second invalidation pulse.

// File: rtl/amu_pkg.sv
package amu_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_LL    = 3'd2,
    OP_SC    = 3'd3,
    OP_CAS   = 3'd4
  } amu_op_e;

  localparam int unsigned NUM_REQ = 2;
  localparam int unsigned OP_W    = 3;

endpackage

// File: rtl/amu_rr_arb.sv
module amu_rr_arb
  import amu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] want,
  output logic [NUM_REQ-1:0] grant
);

  // favour_hi = 1 means requester 1 wins a tie
  logic favour_hi;

  always_comb begin
    if (want == 2'b11) grant = favour_hi ? 2'b10 : 2'b01;
    else               grant = want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      favour_hi <= 1'b0;
    else if (|grant) favour_hi <= grant[0];
  end

endmodule

// File: rtl/amu_resv.sv
module amu_resv #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] take_addr,
  input  logic              drop_own,
  input  logic              peer_wr,
  input  logic [ADDR_W-1:0] peer_addr,
  output logic              held,
  output logic [ADDR_W-1:0] held_addr
);

  logic broken;
  assign broken = peer_wr && held && (peer_addr == held_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_addr <= '0;
    end else if (take) begin
      held      <= 1'b1;
      held_addr <= take_addr;
    end else if (drop_own || broken) begin
      held      <= 1'b0;
    end
  end

endmodule

// File: rtl/amu_core.sv
module amu_core
  import amu_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  amu_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cmp,
  input  logic              resv_ok,
  output logic [DATA_W-1:0] res_data,
  output logic              res_ok,
  output logic              wr_done
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];
  logic [DATA_W-1:0] cur;
  logic              do_wr;

  assign cur = words[addr];

  always_comb begin
    res_data = cur;
    res_ok   = 1'b1;
    do_wr    = 1'b0;
    unique case (op)
      OP_STORE: begin
        res_data = '0;
        do_wr    = 1'b1;
      end
      OP_SC: begin
        res_data = '0;
        res_ok   = resv_ok;
        do_wr    = resv_ok;
      end
      OP_CAS: begin
        res_ok = (cur == cmp);
        do_wr  = (cur == cmp);
      end
      default: ;
    endcase
  end

  assign wr_done = en && do_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) words[w] <= '0;
    end else if (wr_done) begin
      words[addr] <= wdata;
    end
  end

endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
  import amu_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_REQ-1:0]             req_valid,
  output logic [NUM_REQ-1:0]             req_ready,
  input  logic [NUM_REQ-1:0][OP_W-1:0]   req_op,
  input  logic [NUM_REQ-1:0][ADDR_W-1:0] req_addr,
  input  logic [NUM_REQ-1:0][DATA_W-1:0] req_wdata,
  input  logic [NUM_REQ-1:0][DATA_W-1:0] req_cmp,
  output logic [NUM_REQ-1:0]             rsp_valid,
  output logic [NUM_REQ-1:0][DATA_W-1:0] rsp_rdata,
  output logic [NUM_REQ-1:0]             rsp_ok,
  output logic                           inval_pulse,
  output logic [ADDR_W-1:0]              inval_addr
);

  logic [NUM_REQ-1:0]             res_v;
  logic [NUM_REQ-1:0][ADDR_W-1:0] res_a;
  logic [NUM_REQ-1:0]             doomed;
  logic [NUM_REQ-1:0]             port_req;
  logic [NUM_REQ-1:0]             grant;
  logic [NUM_REQ-1:0]             accepted;

  // A conditional store with no matching reservation completes off-port
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    assign doomed[i]   = req_valid[i] && (amu_op_e'(req_op[i]) == OP_SC) &&
                         !(res_v[i] && (res_a[i] == req_addr[i]));
    assign port_req[i] = req_valid[i] && !doomed[i];
  end

  amu_rr_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .want  (port_req),
    .grant (grant)
  );

  assign req_ready = grant | doomed;
  assign accepted  = req_valid & req_ready;

  // Port operand selection
  logic              sel;
  amu_op_e           p_op;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_wdata;
  logic [DATA_W-1:0] p_cmp;
  logic              p_resv_ok;
  logic [DATA_W-1:0] p_data;
  logic              p_ok;
  logic              p_wr;

  assign sel       = grant[1];
  assign p_op      = amu_op_e'(req_op[sel]);
  assign p_addr    = req_addr[sel];
  assign p_wdata   = req_wdata[sel];
  assign p_cmp     = req_cmp[sel];
  assign p_resv_ok = res_v[sel] && (res_a[sel] == p_addr);

  amu_core #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (|grant),
    .op       (p_op),
    .addr     (p_addr),
    .wdata    (p_wdata),
    .cmp      (p_cmp),
    .resv_ok  (p_resv_ok),
    .res_data (p_data),
    .res_ok   (p_ok),
    .wr_done  (p_wr)
  );

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_resv
    amu_resv #(.ADDR_W(ADDR_W)) u_resv (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (grant[i] && (p_op == OP_LL)),
      .take_addr (p_addr),
      .drop_own  (accepted[i] && (amu_op_e'(req_op[i]) == OP_SC)),
      .peer_wr   (p_wr && grant[NUM_REQ-1-i]),
      .peer_addr (p_addr),
      .held      (res_v[i]),
      .held_addr (res_a[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= '0;
      rsp_rdata   <= '0;
      rsp_ok      <= '0;
      inval_pulse <= 1'b0;
      inval_addr  <= '0;
    end else begin
      rsp_valid   <= accepted;
      for (int i = 0; i < NUM_REQ; i++) begin
        if (grant[i]) begin
          rsp_rdata[i] <= p_data;
          rsp_ok[i]    <= p_ok;
        end else begin
          rsp_rdata[i] <= '0;
          rsp_ok[i]    <= 1'b0;
        end
      end
      inval_pulse <= p_wr;
      if (p_wr) inval_addr <= p_addr;
    end
  end

endmodule

// File: rtl/amu_checker.sv
module amu_checker
  import amu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_REQ-1:0]             req_valid,
  input logic [NUM_REQ-1:0]             req_ready,
  input logic [NUM_REQ-1:0][OP_W-1:0]   req_op,
  input logic [NUM_REQ-1:0]             grant,
  input logic [NUM_REQ-1:0]             port_req,
  input logic [NUM_REQ-1:0]             doomed,
  input logic [NUM_REQ-1:0]             res_v,
  input logic [NUM_REQ-1:0]             rsp_valid,
  input logic [NUM_REQ-1:0][DATA_W-1:0] rsp_rdata,
  input logic [NUM_REQ-1:0]             rsp_ok,
  input logic                           inval_pulse
);

  logic [NUM_REQ-1:0] acc;
  assign acc = req_valid & req_ready;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_chk
    p_one_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acc[i] |=> rsp_valid[i]);
    p_no_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc[i] |=> !rsp_valid[i]);
    p_fast_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc[i] && doomed[i]) |=> (!rsp_ok[i] && rsp_rdata[i] == '0));
    p_ll_reserves_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && amu_op_e'(req_op[i]) == OP_LL) |=> res_v[i]);
    p_sc_drops_resv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc[i] && amu_op_e'(req_op[i]) == OP_SC) |=> !res_v[i]);
  end

  p_single_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_rr_after0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_req == 2'b11 && grant == 2'b01) |=> (port_req != 2'b11 || grant == 2'b10));
  p_rr_after1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_req == 2'b11 && grant == 2'b10) |=> (port_req != 2'b11 || grant == 2'b01));
  p_pulse_has_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inval_pulse |-> ((rsp_valid[0] && rsp_ok[0]) || (rsp_valid[1] && rsp_ok[1])));

endmodule

bind atomic_mem_unit amu_checker #(.DATA_W(DATA_W)) u_amu_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .grant       (grant),
  .port_req    (port_req),
  .doomed      (doomed),
  .res_v       (res_v),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .rsp_ok      (rsp_ok),
  .inval_pulse (inval_pulse)
);

// File: tb/tb_atomic_mem_unit.sv
`timescale 1ns/1ps
module tb_atomic_mem_unit;
  import amu_pkg::*;

  localparam int AW = 4;
  localparam int DW = 32;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [1:0]           req_valid = '0;
  logic [1:0]           req_ready;
  logic [1:0][2:0]      req_op = '0;
  logic [1:0][AW-1:0]   req_addr = '0;
  logic [1:0][DW-1:0]   req_wdata = '0;
  logic [1:0][DW-1:0]   req_cmp = '0;
  logic [1:0]           rsp_valid;
  logic [1:0][DW-1:0]   rsp_rdata;
  logic [1:0]           rsp_ok;
  logic                 inval_pulse;
  logic [AW-1:0]        inval_addr;

  always #5 clk = ~clk;

  atomic_mem_unit #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok),
    .inval_pulse(inval_pulse), .inval_addr(inval_addr)
  );

  typedef struct {
    logic [DW-1:0] rdata;
    logic          ok;
    int            cyc;
    string         tag;
  } exp_t;

  exp_t  q0[$];
  exp_t  q1[$];
  int    iq_addr[$];
  string iq_tag[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit good, string tag, string what, longint act, longint exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(int i, logic [DW-1:0] rd, logic ok, string tag);
    exp_t e;
    e.rdata = rd; e.ok = ok; e.cyc = cyc + 1; e.tag = tag;
    if (i == 0) q0.push_back(e); else q1.push_back(e);
  endtask

  task automatic issue(int i, amu_op_e op, int addr, logic [DW-1:0] wd,
                       logic [DW-1:0] cm, logic [DW-1:0] exp_rd, logic exp_ok,
                       bit exp_inv, string tag);
    @(negedge clk);
    req_op[i] = op; req_addr[i] = AW'(addr); req_wdata[i] = wd; req_cmp[i] = cm;
    req_valid[i] = 1'b1;
    #1;
    while (!req_ready[i]) begin @(negedge clk); #1; end
    push(i, exp_rd, exp_ok, tag);
    if (exp_inv) begin iq_addr.push_back(addr); iq_tag.push_back(tag); end
    @(posedge clk); #1;
    req_valid[i] = 1'b0;
  endtask

  task automatic ready_is(logic [1:0] exp, string tag);
    @(negedge clk); #1;
    chk(req_ready == exp, tag, "ready pattern", req_ready, exp);
  endtask

  // Monitor: pops expectations as responses and pulses appear
  initial begin
    forever begin
      @(negedge clk); #2;
      for (int i = 0; i < 2; i++) begin
        if (rsp_valid[i]) begin
          exp_t e;
          if ((i == 0 ? q0.size() : q1.size()) == 0) begin
            chk(0, "R10", "unexpected response", i, -1);
          end else begin
            e = (i == 0) ? q0.pop_front() : q1.pop_front();
            chk(rsp_rdata[i] == e.rdata, e.tag, "rdata", rsp_rdata[i], e.rdata);
            chk(rsp_ok[i] == e.ok, e.tag, "ok", rsp_ok[i], e.ok);
            chk(cyc == e.cyc, "R10", "response cycle", cyc, e.cyc);
          end
        end
      end
      if (inval_pulse) begin
        if (iq_addr.size() == 0) begin
          chk(0, "R4", "unexpected invalidation", inval_addr, -1);
        end else begin
          int    a;
          string t;
          a = iq_addr.pop_front(); t = iq_tag.pop_front();
          chk(int'(inval_addr) == a, t, "inval_addr", inval_addr, a);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R11 reset state
    chk(rsp_valid == 2'b00, "R11", "rsp_valid after reset", rsp_valid, 0);
    chk(inval_pulse == 1'b0, "R11", "inval after reset", inval_pulse, 0);
    chk(req_ready == 2'b00, "R11", "ready idle", req_ready, 0);
    issue(0, OP_LOAD, 5, 0, 0, 0, 1, 0, "R11");

    // R1 plain store / load
    issue(1, OP_STORE, 3, 32'h1111, 0, 0, 1, 1, "R1");
    issue(0, OP_LOAD, 3, 0, 0, 32'h1111, 1, 0, "R1");

    // R2 LL then SC succeeds
    issue(0, OP_LL, 3, 0, 0, 32'h1111, 1, 0, "R2");
    issue(0, OP_SC, 3, 32'h2222, 0, 0, 1, 1, "R2");
    issue(1, OP_LOAD, 3, 0, 0, 32'h2222, 1, 0, "R2");

    // R3 / R4: intervening store breaks reservation, failed SC no pulse
    issue(0, OP_LL, 3, 0, 0, 32'h2222, 1, 0, "R3");
    issue(1, OP_STORE, 3, 32'h0, 0, 0, 1, 1, "R3");
    issue(0, OP_SC, 3, 32'h3333, 0, 0, 0, 0, "R4");
    issue(1, OP_LOAD, 3, 0, 0, 32'h0, 1, 0, "R3");

    // R8 own SC clears; newer LL replaces older
    issue(0, OP_SC, 3, 32'h5555, 0, 0, 0, 0, "R8");
    issue(0, OP_LL, 4, 0, 0, 0, 1, 0, "R8");
    issue(0, OP_LL, 6, 0, 0, 0, 1, 0, "R8");
    issue(0, OP_SC, 4, 32'h44, 0, 0, 0, 0, "R8");
    issue(0, OP_LOAD, 4, 0, 0, 0, 1, 0, "R8");

    // R12 other-address write keeps reservation
    issue(0, OP_LL, 7, 0, 0, 0, 1, 0, "R12");
    issue(1, OP_STORE, 8, 32'h88, 0, 0, 1, 1, "R12");
    issue(0, OP_SC, 7, 32'h77, 0, 0, 1, 1, "R12");
    issue(1, OP_LOAD, 7, 0, 0, 32'h77, 1, 0, "R12");

    // R7 compare-and-swap
    issue(1, OP_CAS, 7, 32'h99, 32'h77, 32'h77, 1, 1, "R7");
    issue(1, OP_CAS, 7, 32'hAA, 32'h77, 32'h99, 0, 0, "R7");
    issue(0, OP_LL, 7, 0, 0, 32'h99, 1, 0, "R7");
    issue(1, OP_CAS, 7, 32'h55, 32'h12, 32'h99, 0, 0, "R7");
    issue(0, OP_SC, 7, 32'hBB, 0, 0, 1, 1, "R7");
    issue(0, OP_LL, 7, 0, 0, 32'hBB, 1, 0, "R7");
    issue(1, OP_CAS, 7, 32'hCC, 32'hBB, 32'hBB, 1, 1, "R7");
    issue(0, OP_SC, 7, 32'hDD, 0, 0, 0, 0, "R3");
    issue(0, OP_LOAD, 7, 0, 0, 32'hCC, 1, 0, "R7");

    // R6 doomed SC runs alongside the other side's store
    fork
      issue(0, OP_SC, 9, 32'hEE, 0, 0, 0, 0, "R6");
      issue(1, OP_STORE, 9, 32'h5, 0, 0, 1, 1, "R6");
      ready_is(2'b11, "R6");
    join

    // R5 race: favour is requester 0 after the two LLs below
    issue(1, OP_LOAD, 9, 0, 0, 32'h5, 1, 0, "R6");
    issue(0, OP_LL, 10, 0, 0, 0, 1, 0, "R5");
    issue(1, OP_LL, 10, 0, 0, 0, 1, 0, "R5");
    fork
      issue(0, OP_SC, 10, 32'hA0, 0, 0, 1, 1, "R5");
      issue(1, OP_SC, 10, 32'hA1, 0, 0, 0, 0, "R5");
      ready_is(2'b01, "R5");
    join
    issue(1, OP_LOAD, 10, 0, 0, 32'hA0, 1, 0, "R5");

    // R9 round-robin: requester 1 served last, so 0 wins the tie
    fork
      issue(0, OP_LOAD, 10, 0, 0, 32'hA0, 1, 0, "R9");
      issue(1, OP_LOAD, 9, 0, 0, 32'h5, 1, 0, "R9");
      ready_is(2'b01, "R9");
    join
    issue(0, OP_LOAD, 3, 0, 0, 0, 1, 0, "R9");
    fork
      issue(0, OP_LOAD, 10, 0, 0, 32'hA0, 1, 0, "R9");
      issue(1, OP_LOAD, 9, 0, 0, 32'h5, 1, 0, "R9");
      ready_is(2'b10, "R9");
    join
    // R1 unused codes behave as load
    issue(1, amu_op_e'(3'd6), 9, 32'h77, 0, 32'h5, 1, 0, "R1");

    repeat (4) @(negedge clk);
    chk(q0.size() == 0, "R10", "pending responses 0", q0.size(), 0);
    chk(q1.size() == 0, "R10", "pending responses 1", q1.size(), 0);
    chk(iq_addr.size() == 0, "R4", "pending invalidations", iq_addr.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule